// File: doc/BRIEF.md
# 8-bit ALU with status register and branch test

This block is the arithmetic and logic unit of a small 8-bit RISC core. It works on two 8-bit operands, or on one 16-bit register pair plus a 6-bit immediate. The result is combinational. An 8-bit status register is updated on a clock edge when `go` is high. Each operation changes only the flags it is defined to affect. The carry input to the with-carry operations and to the rotates is taken from the status register.

The same block sets or clears any single status bit by index. A combinational branch-test output reports whether a chosen status bit equals a requested polarity, which the core uses for conditional branches and skips. The signed branches use bit 4 (S, which holds N xor V): polarity 0 means greater-or-equal and polarity 1 means less-than.

`res_we` tells the core whether the operation produces a value to write back. It is low for compares, for bit set/clear and for reserved codes.

Top module: `alu8_flags`

## Requirements
- R1: The status bits from bit 7 down to bit 0 are I, T, H, S, V, N, Z, C. Reset clears all of them. No operation other than bit set (21) and bit clear (22) changes I or T.
- R2: Add (op 0) and add-with-carry (op 1) give a+b, or a+b+C. They set C from the carry out of bit 7 and H from the carry out of bit 3. V is signed overflow, N is result bit 7, Z is set when the result is zero, and S = N xor V.
- R3: Subtract (op 2), subtract-with-carry (op 3) and negate (op 4, computing 0-a) set C and H from the borrow out of bit 7 and bit 3, and update V, N and S. Z is set when the result is zero, except for op 3: there Z can only be kept or cleared, never set.
- R4: Compare (op 17) and compare-with-carry (op 18) update the flags exactly as ops 2 and 3 do, and hold `res_we` low.
- R5: AND (op 5), OR (op 6) and XOR (op 7) force V to 0 and update N, Z and S. C and H are kept.
- R6: Complement (op 8, computing 0xFF-a) forces C to 1 and V to 0. Increment (op 9) sets V only when a is 0x7F. Decrement (op 10) sets V only when a is 0x80. Ops 8 to 10 update N, Z and S. Ops 9 and 10 keep C and H.
- R7: The shift and rotate ops each produce a result and a new C as follows:
  - Logical left shift (op 11): result is a<<1, C takes bit 7.
  - Logical right shift (op 12): result is a>>1, C takes bit 0.
  - Rotate left (op 13): the old C goes into bit 0, C takes bit 7.
  - Rotate right (op 14): the old C goes into bit 7, C takes bit 0.
  - Arithmetic right shift (op 15): bit 7 is kept, C takes bit 0.

  For all of them V = N xor the new C. N, Z and S are updated. H is kept.
- R8: Nibble swap (op 16) exchanges a[7:4] with a[3:0] and leaves the status register unchanged.
- R9: Word add (op 19) and word subtract (op 20) compute `pair` plus or minus b[5:0] on 16 bits. They set C to the carry or borrow out of bit 15, V to signed overflow, N to bit 15 of the word, Z when the word is zero, and S = N xor V. H is kept.
- R10: Bit set (op 21) and bit clear (op 22) write 1 or 0 into status bit `bit_idx` and change no other bit.
- R11: `cond_true` is high exactly when status bit `bit_idx` equals `want_set`.
- R12: While `go` is low, the status register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Commit the flag update of `op` at this edge |
| op | input | 5 | Operation code (0 to 22) |
| a | input | 8 | First operand |
| b | input | 8 | Second operand or immediate; b[5:0] is the word immediate |
| pair | input | 16 | Register pair for word ops |
| bit_idx | input | 3 | Status bit index for set, clear and test |
| want_set | input | 1 | Polarity that the branch test looks for |
| res | output | 8 | Byte result (low byte of the word for ops 19 and 20) |
| word_res | output | 16 | Word result of ops 19 and 20, otherwise `pair` |
| res_we | output | 1 | Result is to be written back |
| sreg | output | 8 | Status register |
| cond_true | output | 1 | Branch-test outcome |

## Verification
The properties assume that `op` stays within the defined codes 0 to 22, and that `go`, `op` and `bit_idx` are never unknown while reset is released. Codes 23 to 31 are not covered. The bench draws every random opcode with `$urandom_range(22)` and drives all inputs at the falling edge, so they are settled before each rising edge. Bit set and bit clear operations are mixed into the random stream. This gives the carry and zero flags arbitrary values before the with-carry, rotate and sticky-zero operations.

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [4:0]  op,
  input  logic [7:0]  a,
  input  logic [7:0]  b,
  input  logic [15:0] pair,
  input  logic [2:0]  bit_idx,
  input  logic        want_set,
  output logic [7:0]  res,
  output logic [15:0] word_res,
  output logic        res_we,
  output logic [7:0]  sreg,
  output logic        cond_true
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3;
  localparam logic [4:0] OP_NEG = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7;
  localparam logic [4:0] OP_COM = 5'd8,  OP_INC = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11;
  localparam logic [4:0] OP_LSR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15;
  localparam logic [4:0] OP_SWP = 5'd16, OP_CP  = 5'd17, OP_CPC = 5'd18, OP_WAD = 5'd19;
  localparam logic [4:0] OP_WSB = 5'd20, OP_SET = 5'd21, OP_CLR = 5'd22;
  localparam int FC = 0, FZ = 1, FN = 2, FV = 3, FS = 4, FH = 5;

  logic        c_old, use_c, cin, sticky;
  logic [7:0]  sub_a, sub_b;
  logic [8:0]  add9, sub9;
  logic [4:0]  add5, sub5;
  logic [16:0] wadd, wsub;
  logic [7:0]  nx, r;
  logic [15:0] wr;
  logic        we, byte_nz, shift_v;

  assign c_old  = sreg[FC];
  assign use_c  = (op == OP_ADC) || (op == OP_SBC) || (op == OP_CPC);
  assign cin    = use_c & c_old;
  assign sticky = (op == OP_SBC) || (op == OP_CPC);
  assign sub_a  = (op == OP_NEG) ? 8'd0 : a;
  assign sub_b  = (op == OP_NEG) ? a : b;
  assign add9   = {1'b0, a} + {1'b0, b} + {8'd0, cin};
  assign add5   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, cin};
  assign sub9   = {1'b0, sub_a} - {1'b0, sub_b} - {8'd0, cin};
  assign sub5   = {1'b0, sub_a[3:0]} - {1'b0, sub_b[3:0]} - {4'd0, cin};
  assign wadd   = {1'b0, pair} + {11'd0, b[5:0]};
  assign wsub   = {1'b0, pair} - {11'd0, b[5:0]};

  always_comb begin
    nx      = sreg;
    r       = a;
    wr      = pair;
    we      = 1'b1;
    byte_nz = 1'b1;
    shift_v = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        r      = add9[7:0];
        nx[FC] = add9[8];
        nx[FH] = add5[4];
        nx[FV] = (a[7] == b[7]) && (r[7] != a[7]);
      end
      OP_SUB, OP_SBC, OP_NEG, OP_CP, OP_CPC: begin
        r      = sub9[7:0];
        nx[FC] = sub9[8];
        nx[FH] = sub5[4];
        nx[FV] = (sub_a[7] != sub_b[7]) && (r[7] != sub_a[7]);
        we     = !((op == OP_CP) || (op == OP_CPC));
      end
      OP_AND: begin r = a & b; nx[FV] = 1'b0; end
      OP_OR:  begin r = a | b; nx[FV] = 1'b0; end
      OP_XOR: begin r = a ^ b; nx[FV] = 1'b0; end
      OP_COM: begin r = ~a; nx[FC] = 1'b1; nx[FV] = 1'b0; end
      OP_INC: begin r = a + 8'd1; nx[FV] = (a == 8'h7F); end
      OP_DEC: begin r = a - 8'd1; nx[FV] = (a == 8'h80); end
      OP_LSL: begin r = {a[6:0], 1'b0};  nx[FC] = a[7]; shift_v = 1'b1; end
      OP_LSR: begin r = {1'b0, a[7:1]};  nx[FC] = a[0]; shift_v = 1'b1; end
      OP_ROL: begin r = {a[6:0], c_old}; nx[FC] = a[7]; shift_v = 1'b1; end
      OP_ROR: begin r = {c_old, a[7:1]}; nx[FC] = a[0]; shift_v = 1'b1; end
      OP_ASR: begin r = {a[7], a[7:1]};  nx[FC] = a[0]; shift_v = 1'b1; end
      OP_SWP: begin r = {a[3:0], a[7:4]}; byte_nz = 1'b0; end
      OP_WAD, OP_WSB: begin
        byte_nz = 1'b0;
        wr      = (op == OP_WAD) ? wadd[15:0] : wsub[15:0];
        r       = wr[7:0];
        nx[FC]  = (op == OP_WAD) ? wadd[16] : wsub[16];
        nx[FV]  = (op == OP_WAD) ? (!pair[15] && wr[15]) : (pair[15] && !wr[15]);
        nx[FN]  = wr[15];
        nx[FZ]  = (wr == 16'd0);
        nx[FS]  = nx[FN] ^ nx[FV];
      end
      OP_SET: begin nx[bit_idx] = 1'b1; we = 1'b0; byte_nz = 1'b0; end
      OP_CLR: begin nx[bit_idx] = 1'b0; we = 1'b0; byte_nz = 1'b0; end
      default: begin we = 1'b0; byte_nz = 1'b0; end
    endcase
    if (byte_nz) begin
      nx[FN] = r[7];
      nx[FZ] = (r == 8'd0) && (!sticky || sreg[FZ]);
      if (shift_v) nx[FV] = nx[FN] ^ nx[FC];
      nx[FS] = nx[FN] ^ nx[FV];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sreg <= 8'd0;
    else if (go) sreg <= nx;
  end

  assign res       = r;
  assign word_res  = wr;
  assign res_we    = we;
  assign cond_true = (sreg[bit_idx] == want_set);
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic [4:0] op,
  input logic [2:0] bit_idx,
  input logic       res_we,
  input logic [7:0] sreg
);
  p_reset_r1: assert property (@(posedge clk) !rst_n |=> sreg == 8'd0);

  p_it_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go && op != 5'd21 && op != 5'd22 |=> sreg[7:6] == $past(sreg[7:6]));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go && op <= 5'd15 |=> sreg[4] == (sreg[2] ^ sreg[3]));

  p_nowrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go && (op == 5'd17 || op == 5'd18) |-> !res_we);

  p_logic_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go && op >= 5'd5 && op <= 5'd7 |=>
      !sreg[3] && sreg[0] == $past(sreg[0]) && sreg[5] == $past(sreg[5]));

  p_com_r6: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 5'd8 |=> sreg[0] && !sreg[3]);

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 5'd16 |=> $stable(sreg));

  p_bset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 5'd21 |=> sreg == ($past(sreg) | (8'h01 << $past(bit_idx))));

  p_bclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go && op == 5'd22 |=> sreg == ($past(sreg) & ~(8'h01 << $past(bit_idx))));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(sreg));
endmodule

bind alu8_flags alu8_flags_chk chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .op(op), .bit_idx(bit_idx),
  .res_we(res_we), .sreg(sreg)
);

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [4:0]  op = 5'd0;
  logic [7:0]  a = 8'd0, b = 8'd0;
  logic [15:0] pair = 16'd0;
  logic [2:0]  bit_idx = 3'd0;
  logic        want_set = 1'b0;
  logic [7:0]  res, sreg;
  logic [15:0] word_res;
  logic        res_we, cond_true;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] msreg = 8'd0;

  always #5 clk = ~clk;

  alu8_flags dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .a(a), .b(b), .pair(pair),
    .bit_idx(bit_idx), .want_set(want_set), .res(res), .word_res(word_res),
    .res_we(res_we), .sreg(sreg), .cond_true(cond_true)
  );

  function automatic string tag_of(input logic [4:0] o);
    if (o <= 5'd1)  return "R2";
    if (o <= 5'd4)  return "R3";
    if (o <= 5'd7)  return "R5";
    if (o <= 5'd10) return "R6";
    if (o <= 5'd15) return "R7";
    if (o == 5'd16) return "R8";
    if (o <= 5'd18) return "R4";
    if (o <= 5'd20) return "R9";
    return "R10";
  endfunction

  // returns {we, word[15:0], res[7:0], new status[7:0]}
  function automatic logic [32:0] model(input logic [4:0] o, input logic [7:0] x0,
      input logic [7:0] y0, input logic [15:0] p, input logic [2:0] idx, input logic [7:0] s);
    logic [7:0] r, n, x, y;
    logic [15:0] w;
    logic we, nz, stk, shf, cc;
    r = x0; w = p; we = 1'b1; n = s; nz = 1'b1; stk = 1'b0; shf = 1'b0;
    case (o)
      5'd0, 5'd1: begin
        cc = (o == 5'd1) ? s[0] : 1'b0;
        r = x0 + y0 + {7'd0, cc};
        n[5] = (x0[3] & y0[3]) | (y0[3] & ~r[3]) | (~r[3] & x0[3]);
        n[0] = (x0[7] & y0[7]) | (y0[7] & ~r[7]) | (~r[7] & x0[7]);
        n[3] = (x0[7] & y0[7] & ~r[7]) | (~x0[7] & ~y0[7] & r[7]);
      end
      5'd2, 5'd3, 5'd4, 5'd17, 5'd18: begin
        x = (o == 5'd4) ? 8'd0 : x0;
        y = (o == 5'd4) ? x0 : y0;
        cc = (o == 5'd3 || o == 5'd18) ? s[0] : 1'b0;
        stk = (o == 5'd3 || o == 5'd18);
        r = x - y - {7'd0, cc};
        n[5] = (~x[3] & y[3]) | (y[3] & r[3]) | (r[3] & ~x[3]);
        n[0] = (~x[7] & y[7]) | (y[7] & r[7]) | (r[7] & ~x[7]);
        n[3] = (x[7] & ~y[7] & ~r[7]) | (~x[7] & y[7] & r[7]);
        we = !(o == 5'd17 || o == 5'd18);
      end
      5'd5: begin r = x0 & y0; n[3] = 1'b0; end
      5'd6: begin r = x0 | y0; n[3] = 1'b0; end
      5'd7: begin r = x0 ^ y0; n[3] = 1'b0; end
      5'd8: begin r = 8'hFF - x0; n[0] = 1'b1; n[3] = 1'b0; end
      5'd9: begin r = x0 + 8'd1; n[3] = (r == 8'h80); end
      5'd10: begin r = x0 - 8'd1; n[3] = (r == 8'h7F); end
      5'd11: begin r = x0 << 1; n[0] = x0[7]; shf = 1'b1; end
      5'd12: begin r = x0 >> 1; n[0] = x0[0]; shf = 1'b1; end
      5'd13: begin r = {x0[6:0], s[0]}; n[0] = x0[7]; shf = 1'b1; end
      5'd14: begin r = {s[0], x0[7:1]}; n[0] = x0[0]; shf = 1'b1; end
      5'd15: begin r = $signed(x0) >>> 1; n[0] = x0[0]; shf = 1'b1; end
      5'd16: begin r = {x0[3:0], x0[7:4]}; nz = 1'b0; end
      5'd19, 5'd20: begin
        nz = 1'b0;
        w = (o == 5'd19) ? p + {10'd0, y0[5:0]} : p - {10'd0, y0[5:0]};
        r = w[7:0];
        n[0] = (o == 5'd19) ? (p[15] & ~w[15]) : (~p[15] & w[15]);
        n[3] = (o == 5'd19) ? (~p[15] & w[15]) : (p[15] & ~w[15]);
        n[2] = w[15];
        n[1] = (w == 16'd0);
        n[4] = n[2] ^ n[3];
      end
      5'd21: begin n[idx] = 1'b1; we = 1'b0; nz = 1'b0; end
      default: begin n[idx] = 1'b0; we = 1'b0; nz = 1'b0; end
    endcase
    if (nz) begin
      n[2] = r[7];
      n[1] = (r == 8'd0) && (!stk || s[1]);
      if (shf) n[3] = n[2] ^ n[0];
      n[4] = n[2] ^ n[3];
    end
    return {we, w, r, n};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic g, input logic [4:0] o, input logic [7:0] xa,
      input logic [7:0] xb, input logic [15:0] xp, input logic [2:0] xi, input logic xw);
    logic [32:0] e;
    string t;
    @(negedge clk);
    go = g; op = o; a = xa; b = xb; pair = xp; bit_idx = xi; want_set = xw;
    #1;
    e = model(o, xa, xb, xp, xi, msreg);
    t = tag_of(o);
    check(res == e[15:8], t, "res", {24'd0, res}, {24'd0, e[15:8]});
    check(res_we == e[32], t, "res_we", {31'd0, res_we}, {31'd0, e[32]});
    check(word_res == e[31:16], t, "word_res", {16'd0, word_res}, {16'd0, e[31:16]});
    check(cond_true == (msreg[xi] == xw), "R11", "cond_true",
          {31'd0, cond_true}, {31'd0, msreg[xi] == xw});
    @(posedge clk);
    #1;
    if (g) msreg = e[7:0];
    else t = "R12";
    check(sreg == msreg, t, "sreg", {24'd0, sreg}, {24'd0, msreg});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sreg == 8'd0, "R1", "reset sreg", {24'd0, sreg}, 32'd0);
    rst_n = 1'b1;
    msreg = 8'd0;

    // directed corners
    step(1, 5'd0, 8'h80, 8'h80, 16'h0, 3'd0, 1'b1);  // R2 carry, overflow, zero
    step(1, 5'd0, 8'h0F, 8'h01, 16'h0, 3'd5, 1'b1);  // R2 half carry
    step(1, 5'd1, 8'h7F, 8'h00, 16'h0, 3'd3, 1'b1);  // R2 carry-in
    step(1, 5'd2, 8'h00, 8'h01, 16'h0, 3'd0, 1'b1);  // R3 borrow
    step(1, 5'd2, 8'h80, 8'h01, 16'h0, 3'd4, 1'b1);  // R3 then signed less-than R11
    step(1, 5'd4, 8'h80, 8'h00, 16'h0, 3'd3, 1'b1);  // R3 negate 0x80
    step(1, 5'd4, 8'h00, 8'h00, 16'h0, 3'd0, 1'b0);  // R3 negate zero, no borrow
    step(1, 5'd21, 8'h00, 8'h00, 16'h0, 3'd1, 1'b0); // R10 set Z
    step(1, 5'd22, 8'h00, 8'h00, 16'h0, 3'd0, 1'b0); // R10 clear C
    step(1, 5'd18, 8'h42, 8'h42, 16'h0, 3'd1, 1'b1); // R4 Z stays set
    step(1, 5'd18, 8'h43, 8'h42, 16'h0, 3'd1, 1'b1); // R4 Z cleared
    step(1, 5'd18, 8'h42, 8'h42, 16'h0, 3'd1, 1'b0); // R4 Z not re-set
    step(1, 5'd3, 8'h10, 8'h10, 16'h0, 3'd1, 1'b0);  // R3 sticky zero
    step(1, 5'd9, 8'h7F, 8'h00, 16'h0, 3'd3, 1'b1);  // R6 inc overflow
    step(1, 5'd10, 8'h80, 8'h00, 16'h0, 3'd3, 1'b1); // R6 dec overflow
    step(1, 5'd8, 8'h00, 8'h00, 16'h0, 3'd0, 1'b1);  // R6 complement
    step(1, 5'd13, 8'h80, 8'h00, 16'h0, 3'd0, 1'b1); // R7 rotate left with C
    step(1, 5'd14, 8'h01, 8'h00, 16'h0, 3'd0, 1'b1); // R7 rotate right
    step(1, 5'd15, 8'h81, 8'h00, 16'h0, 3'd2, 1'b1); // R7 arithmetic shift
    step(1, 5'd16, 8'hA5, 8'h00, 16'h0, 3'd0, 1'b0); // R8 swap
    step(1, 5'd19, 8'h00, 8'h01, 16'hFFFF, 3'd0, 1'b1); // R9 word wrap
    step(1, 5'd19, 8'h00, 8'h3F, 16'h7FF0, 3'd3, 1'b1); // R9 word overflow
    step(1, 5'd20, 8'h00, 8'h01, 16'h0000, 3'd0, 1'b1); // R9 word borrow
    step(1, 5'd20, 8'h00, 8'h01, 16'h8000, 3'd3, 1'b1); // R9 word overflow
    step(1, 5'd21, 8'h00, 8'h00, 16'h0, 3'd7, 1'b1); // R10 set I
    step(1, 5'd21, 8'h00, 8'h00, 16'h0, 3'd6, 1'b1); // R10 set T
    step(1, 5'd0, 8'h01, 8'h01, 16'h0, 3'd7, 1'b1);  // R1 I and T kept
    step(0, 5'd22, 8'h00, 8'h00, 16'h0, 3'd7, 1'b1); // R12 idle clear ignored

    for (int i = 0; i < 30000; i++) begin
      logic g;
      g = ($urandom_range(15) != 0);
      step(g, 5'($urandom_range(22)), 8'($urandom), 8'($urandom), 16'($urandom),
           3'($urandom_range(7)), 1'($urandom_range(1)));
    end

    @(negedge clk);
    go = 1'b0;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule